// File: doc/BRIEF.md
# Sampled PI Regulator with Conditional Integration

This block is a fixed-point proportional-integral regulator for power-conversion control loops. Each time the sample strobe is high for one clock, it takes a setpoint and a measured value, forms the signed error, and produces a new control word that is held until the next strobe. The proportional path uses its gain as given. The integral path adds error times a gain to an accumulator on every accepted sample. That gain is already scaled by the sample period, which matches the backward-difference mapping s = (1 − z⁻¹)/T, so the current sample counts towards the integral.

The gains and the two output limits are plain inputs, sampled on each strobe. One instance can therefore run a fast inner current loop, with a small proportional gain and a large integral gain, or a slow outer voltage loop, with a larger proportional gain and a small integral gain. Only the parameters or the applied values change.

Anti-windup works by conditional integration. The block first computes the output the loop would give if it accepted the new integral value. If that trial output lies beyond a limit and the error pushes further outwards, the accumulator keeps its old value. If the error pulls the output back towards the permitted band, the accumulator still integrates, so the loop recovers without delay.

Top module: `euler_pi_reg`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) clears the accumulator and the output u_o to zero, and it takes priority over a strobe in the same cycle.
- R2: u_o changes only at the clock edge where sample_i is 1; between strobes it holds its value, whatever the other inputs do.
- R3: The error is ref_i − fbk_i, with both inputs signed two's complement. The proportional term is floor(error × kp_i / 2^8), where kp_i is unsigned with 8 fraction bits (256 means a gain of 1.0).
- R4: On each strobe that is not frozen, the accumulator gains error × ki_i, where ki_i is unsigned and already includes the sample period. The integral term is floor(accumulator / 2^16), and the new sample is part of the output of the same strobe.
- R5: The output is the sum of the proportional and integral terms, bounded by the limits. If the sum is greater than lim_hi_i the output is lim_hi_i. Otherwise, if the sum is less than lim_lo_i, the output is lim_lo_i. Otherwise the output is the sum. The upper test is made first, so with lim_lo_i > lim_hi_i the output is lim_hi_i when the sum exceeds lim_hi_i and lim_lo_i otherwise.
- R6: If the trial output (with the new integral) is above lim_hi_i while the error is positive, or below lim_lo_i while the error is negative, the accumulator keeps its value. The output is then formed from the old integral.
- R7: If the trial output is beyond a limit but the error has the opposite sign, the accumulator does integrate. A saturated loop starts to unwind on the first strobe after the error reverses.
- R8: The gains and limits present in the strobe cycle are the ones used for that strobe. Changing them from one strobe to the next takes effect at once, with no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | One-cycle strobe that starts a regulator update |
| ref_i | input | DW (16) | Setpoint, signed |
| fbk_i | input | DW (16) | Measured value, signed |
| kp_i | input | GW (16) | Proportional gain, unsigned, KP_FRAC fraction bits |
| ki_i | input | GW (16) | Integral gain times sample period, unsigned, KI_FRAC fraction bits |
| lim_lo_i | input | OW (16) | Lower output limit, signed |
| lim_hi_i | input | OW (16) | Upper output limit, signed |
| u_o | output | OW (16) | Registered control output, signed |

## Verification
The output clamp and the freeze decision of the integrator fall in the same strobe. One trial sum decides both whether the word is bounded and whether the accumulator keeps its value. The bench provokes this by driving the error into a narrow band until the trial output crosses the upper limit, holding the error there for several strobes, and then reversing its sign. The frozen or unwinding accumulator is judged at the ports: a later strobe with zero proportional gain and zero error makes u_o equal to the bare integral term, which must match the value a reference model predicts under the freeze rule.

// File: rtl/euler_pi_pkg.sv
package euler_pi_pkg;

   // Rounding applied when a fixed-point product is scaled back to integer units
   typedef enum logic [0:0] {
      RND_FLOOR   = 1'b0,
      RND_HALF_UP = 1'b1
   } round_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pi_scale.sv
// Arithmetic right shift of a fixed-point value, with a rounding choice.
module pi_scale
   import euler_pi_pkg::*;
#(
   parameter int     W     = 36,
   parameter int     SH    = 16,
   parameter round_e ROUND = RND_FLOOR
) (
   input  logic signed [W-1:0] val_i,
   output logic signed [W-1:0] val_o
);

   generate
      if (SH < 1 || SH >= W) begin : g_bad_shift
         $error("pi_scale: SH must lie in 1..W-1");
      end

      if (ROUND == RND_FLOOR) begin : g_floor
         assign val_o = val_i >>> SH;
      end else begin : g_half_up
         localparam logic signed [W:0] HALF = (W+1)'(1) << (SH - 1);
         logic signed [W:0] biased;
         assign biased = {val_i[W-1], val_i} + HALF;
         assign val_o  = W'(biased >>> SH);
      end
   endgenerate

endmodule

// File: rtl/pi_limiter.sv
// Bounds a wide sum to an output word; upper bound is tested first.
module pi_limiter #(
   parameter int SUM_W = 37,
   parameter int OW    = 16
) (
   input  logic signed [SUM_W-1:0] sum_i,
   input  logic signed [OW-1:0]    hi_i,
   input  logic signed [OW-1:0]    lo_i,
   output logic signed [OW-1:0]    val_o,
   output logic                    above_o,
   output logic                    below_o
);

   logic signed [SUM_W-1:0] hi_x;
   logic signed [SUM_W-1:0] lo_x;

   generate
      if (SUM_W <= OW) begin : g_bad_width
         $error("pi_limiter: SUM_W must exceed OW");
      end
   endgenerate

   assign hi_x    = SUM_W'(hi_i);
   assign lo_x    = SUM_W'(lo_i);
   assign above_o = (sum_i > hi_x);
   assign below_o = (sum_i < lo_x);

   always_comb begin
      if (above_o)      val_o = hi_i;
      else if (below_o) val_o = lo_i;
      else              val_o = sum_i[OW-1:0];
   end

endmodule

// File: rtl/pi_integrator.sv
// Saturating accumulator with conditional integration.
module pi_integrator #(
   parameter int ERR_W = 17,
   parameter int GW    = 16,
   parameter int ACC_W = 36
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    sample_i,
   input  logic signed [ERR_W-1:0] err_i,
   input  logic [GW-1:0]           ki_i,
   input  logic                    trial_hi_i,
   input  logic                    trial_lo_i,
   output logic signed [ACC_W-1:0] acc_o,
   output logic signed [ACC_W-1:0] trial_o,
   output logic                    hold_o
);

   localparam int INC_W = ERR_W + GW + 1;
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   generate
      if (ACC_W <= INC_W) begin : g_bad_acc
         $error("pi_integrator: ACC_W must exceed the increment width");
      end
   endgenerate

   logic signed [INC_W-1:0] inc;
   logic signed [ACC_W:0]   sum_w;
   logic signed [ACC_W-1:0] acc_q;
   logic                    err_pos;
   logic                    err_neg;

   assign inc   = err_i * $signed({1'b0, ki_i});
   assign sum_w = {acc_q[ACC_W-1], acc_q} + (ACC_W+1)'(inc);

   always_comb begin
      if (sum_w[ACC_W] != sum_w[ACC_W-1])
         trial_o = sum_w[ACC_W] ? ACC_MIN : ACC_MAX;
      else
         trial_o = sum_w[ACC_W-1:0];
   end

   assign err_neg = err_i[ERR_W-1];
   assign err_pos = !err_i[ERR_W-1] && (|err_i);
   assign hold_o  = (trial_hi_i && err_pos) || (trial_lo_i && err_neg);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         acc_q <= '0;
      else if (sample_i && !hold_o)
         acc_q <= trial_o;
   end

   assign acc_o = acc_q;

   // R6
   freeze_outward_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sample_i && trial_hi_i && (err_i > 0)) |=> (acc_q == $past(acc_q)));

   // R7
   unwind_inward_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sample_i && trial_hi_i && !trial_lo_i && (err_i < 0) && (ki_i != '0)
       && (acc_q != ACC_MIN)) |=> (acc_q < $past(acc_q)));

endmodule

// File: rtl/euler_pi_reg.sv
// Sampled PI regulator, backward-difference integral, conditional integration.
module euler_pi_reg
   import euler_pi_pkg::*;
#(
   parameter int     DW      = 16,
   parameter int     GW      = 16,
   parameter int     OW      = 16,
   parameter int     KP_FRAC = 8,
   parameter int     KI_FRAC = 16,
   parameter round_e ROUND   = RND_FLOOR
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 sample_i,
   input  logic signed [DW-1:0] ref_i,
   input  logic signed [DW-1:0] fbk_i,
   input  logic [GW-1:0]        kp_i,
   input  logic [GW-1:0]        ki_i,
   input  logic signed [OW-1:0] lim_lo_i,
   input  logic signed [OW-1:0] lim_hi_i,
   output logic signed [OW-1:0] u_o
);

   localparam int ERR_W = DW + 1;
   localparam int PW    = ERR_W + GW + 1;
   localparam int ACC_W = imax(OW + KI_FRAC + 4, PW + 1);
   localparam int SUM_W = imax(PW, ACC_W) + 1;
   localparam int N_LIM = 2;

   generate
      if (DW < 2 || GW < 2 || OW < 2) begin : g_bad_widths
         $error("euler_pi_reg: DW, GW and OW must be at least 2");
      end
      if (KP_FRAC < 1 || KP_FRAC >= PW) begin : g_bad_kp_frac
         $error("euler_pi_reg: KP_FRAC out of range");
      end
      if (KI_FRAC < 1 || KI_FRAC >= ACC_W) begin : g_bad_ki_frac
         $error("euler_pi_reg: KI_FRAC out of range");
      end
   endgenerate

   logic signed [ERR_W-1:0] err;
   logic signed [PW-1:0]    p_raw;
   logic signed [PW-1:0]    p_term;
   logic signed [ACC_W-1:0] acc;
   logic signed [ACC_W-1:0] acc_trial;
   logic signed [ACC_W-1:0] i_trial;
   logic signed [ACC_W-1:0] i_old;
   logic                    hold;
   logic signed [SUM_W-1:0] lim_sum [N_LIM];
   logic signed [OW-1:0]    lim_val [N_LIM];
   logic [N_LIM-1:0]        lim_above;
   logic [N_LIM-1:0]        lim_below;
   logic signed [OW-1:0]    u_next;
   logic signed [OW-1:0]    u_q;

   // error and proportional product
   assign err   = $signed({ref_i[DW-1], ref_i}) - $signed({fbk_i[DW-1], fbk_i});
   assign p_raw = err * $signed({1'b0, kp_i});

   pi_scale #(.W(PW), .SH(KP_FRAC), .ROUND(ROUND)) u_scale_p (
      .val_i (p_raw),
      .val_o (p_term)
   );

   pi_integrator #(.ERR_W(ERR_W), .GW(GW), .ACC_W(ACC_W)) u_integ (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .sample_i   (sample_i),
      .err_i      (err),
      .ki_i       (ki_i),
      .trial_hi_i (lim_above[0]),
      .trial_lo_i (lim_below[0]),
      .acc_o      (acc),
      .trial_o    (acc_trial),
      .hold_o     (hold)
   );

   pi_scale #(.W(ACC_W), .SH(KI_FRAC), .ROUND(ROUND)) u_scale_it (
      .val_i (acc_trial),
      .val_o (i_trial)
   );

   pi_scale #(.W(ACC_W), .SH(KI_FRAC), .ROUND(ROUND)) u_scale_io (
      .val_i (acc),
      .val_o (i_old)
   );

   // index 0: sum with the new integral, index 1: sum with the held integral
   assign lim_sum[0] = SUM_W'(p_term) + SUM_W'(i_trial);
   assign lim_sum[1] = SUM_W'(p_term) + SUM_W'(i_old);

   generate
      for (genvar g = 0; g < N_LIM; g++) begin : g_lim
         pi_limiter #(.SUM_W(SUM_W), .OW(OW)) u_lim (
            .sum_i   (lim_sum[g]),
            .hi_i    (lim_hi_i),
            .lo_i    (lim_lo_i),
            .val_o   (lim_val[g]),
            .above_o (lim_above[g]),
            .below_o (lim_below[g])
         );
      end
   endgenerate

   assign u_next = hold ? lim_val[1] : lim_val[0];

   always_ff @(posedge clk_i) begin
      if (rst_i)
         u_q <= '0;
      else if (sample_i)
         u_q <= u_next;
   end

   assign u_o = u_q;

   // R1
   logic rst_seen;
   always_ff @(posedge clk_i) begin
      rst_seen <= rst_i;
      if (rst_seen === 1'b1) begin
         reset_clear_chk: assert (u_q == '0)
            else $error("output not cleared by reset");
      end
   end

   // R2
   hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !sample_i |=> $stable(u_o));

   // R5
   in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sample_i && (lim_hi_i >= lim_lo_i)) |=>
         ((u_o <= $past(lim_hi_i)) && (u_o >= $past(lim_lo_i))));

   // R5
   held_upper_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (sample_i && hold && lim_above[1]) |=> (u_o == $past(lim_hi_i)));

endmodule

// File: tb/test_euler_pi_reg.sv
`timescale 1ns/1ps
module test_euler_pi_reg;

   localparam int  KPF  = 8;
   localparam int  KIF  = 16;
   localparam longint AMAX = 64'sd34359738367;
   localparam longint AMIN = -64'sd34359738368;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               sample = 1'b0;
   logic signed [15:0] ref_v = '0;
   logic signed [15:0] fbk_v = '0;
   logic [15:0]        kp_v = '0;
   logic [15:0]        ki_v = '0;
   logic signed [15:0] lo_v = '0;
   logic signed [15:0] hi_v = '0;
   logic signed [15:0] u;

   always #2 clk = ~clk;

   euler_pi_reg i_euler_pi_reg (
      .clk_i    (clk),
      .rst_i    (rst),
      .sample_i (sample),
      .ref_i    (ref_v),
      .fbk_i    (fbk_v),
      .kp_i     (kp_v),
      .ki_i     (ki_v),
      .lim_lo_i (lo_v),
      .lim_hi_i (hi_v),
      .u_o      (u)
   );

   typedef struct {
      longint v;
      string  req;
   } exp_t;

   exp_t   scb[$];
   int     checks = 0;
   int     fails = 0;
   longint m_acc = 0;
   longint last_exp = 0;
   bit     done = 1'b0;

   task automatic chk(input longint act, input longint exp, input string req);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint acc_sat(input longint x);
      if (x > AMAX) return AMAX;
      if (x < AMIN) return AMIN;
      return x;
   endfunction

   // driver: presents one strobe and pushes the model's prediction
   task automatic strobe(input longint r, input longint f, input longint kp,
                         input longint ki, input longint lo, input longint hi,
                         input string req);
      longint e, p, trial, ut, s, ue;
      bit     hold;
      @(negedge clk);
      ref_v  = 16'(r);
      fbk_v  = 16'(f);
      kp_v   = 16'(kp);
      ki_v   = 16'(ki);
      lo_v   = 16'(lo);
      hi_v   = 16'(hi);
      sample = 1'b1;
      e     = r - f;
      p     = (e * kp) >>> KPF;
      trial = acc_sat(m_acc + e * ki);
      ut    = p + (trial >>> KIF);
      hold  = ((ut > hi) && (e > 0)) || ((ut < lo) && (e < 0));
      if (!hold) m_acc = trial;
      s  = p + (m_acc >>> KIF);
      if (s > hi)      ue = hi;
      else if (s < lo) ue = lo;
      else             ue = s;
      scb.push_back('{ue, req});
      last_exp = ue;
      @(negedge clk);
      sample = 1'b0;
   endtask

   // monitor: compares the registered output one edge after each strobe
   initial begin
      forever begin
         @(posedge clk);
         if (sample === 1'b1 && rst === 1'b0) begin
            #1;
            if (scb.size() == 0) begin
               chk(u, 99999, "R2 unexpected update");
            end else begin
               exp_t x;
               x = scb.pop_front();
               chk(u, x.v, x.req);
            end
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst    = 1'b1;
      sample = 1'b0;
      repeat (2) @(negedge clk);
      chk(u, 0, "R1 reset clears output");
      rst      = 1'b0;
      m_acc    = 0;
      last_exp = 0;
   endtask

   // R2: disturb every input without a strobe; output must stay put
   task automatic idle_check(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ref_v = 16'($urandom_range(0, 4000));
         fbk_v = 16'($urandom_range(0, 4000));
         kp_v  = 16'($urandom_range(0, 5000));
         ki_v  = 16'($urandom_range(0, 50000));
         lo_v  = -16'sd500;
         hi_v  = 16'sd500;
         @(posedge clk);
         #1;
         chk(u, last_exp, "R2 held between strobes");
      end
   endtask

   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(u, 0, "R1 output zero in reset");
      rst = 1'b0;
      @(negedge clk);
      chk(u, 0, "R1 output zero after reset");

      // R3 / R8: proportional only, gain changed between strobes
      strobe(100, 40, 256, 0, -32768, 32767, "R3 unity gain");
      strobe(-500, 300, 256, 0, -32768, 32767, "R3 negative error");
      strobe(20, 57, 691, 0, -32768, 32767, "R3 floor of negative product");
      strobe(1000, 0, 3151, 0, -32768, 32767, "R8 new gain applied");
      idle_check(4);

      // R4: integral only, current sample included
      do_reset();
      strobe(3, 0, 0, 32768, -32768, 32767, "R4 first sample counted");
      strobe(3, 0, 0, 32768, -32768, 32767, "R4 accumulate");
      strobe(3, 0, 0, 32768, -32768, 32767, "R4 accumulate");
      strobe(3, 0, 0, 32768, -32768, 32767, "R4 accumulate");
      strobe(0, 5, 0, 32768, -32768, 32767, "R4 negative error");
      strobe(0, 5, 0, 32768, -32768, 32767, "R4 negative error");
      strobe(10, 0, 256, 29768, -32768, 32767, "R4 with proportional");

      // R5 / R6: drive into the upper limit, integrator must freeze
      do_reset();
      for (int k = 0; k < 10; k++)
         strobe(50, 0, 256, 32768, -100, 200, "R5/R6 approach upper limit");
      strobe(0, 0, 0, 0, -100, 200, "R6 frozen integral readback");

      // R7: reverse the error while saturated, integrator unwinds
      for (int k = 0; k < 6; k++)
         strobe(0, 10, 256, 32768, -100, 100, "R7 unwind from upper limit");
      strobe(0, 0, 0, 0, -32768, 32767, "R7 unwound integral readback");

      // R6 lower side
      for (int k = 0; k < 8; k++)
         strobe(-40, 0, 256, 65535, -60, 60, "R6 approach lower limit");
      strobe(0, 0, 0, 0, -32768, 32767, "R6 lower frozen readback");

      // R5: limits crossed over, upper tested first
      do_reset();
      strobe(30, 0, 256, 0, 50, 10, "R5 crossed limits above");
      strobe(0, 0, 256, 0, 50, 10, "R5 crossed limits below");
      strobe(5000, 0, 256, 0, -7, 7, "R5 clamp high");
      strobe(-5000, 0, 256, 0, -7, 7, "R5 clamp low");
      idle_check(3);

      // R1: reset in mid-run discards the accumulated integral
      strobe(200, 0, 0, 40000, -32768, 32767, "R4 build integral");
      strobe(200, 0, 0, 40000, -32768, 32767, "R4 build integral");
      do_reset();
      strobe(0, 0, 0, 0, -32768, 32767, "R1 integral cleared");

      // R3 / R4 / R5 mixed patterns
      for (int k = 0; k < 40; k++) begin
         longint r, f, kp, ki, lim;
         r   = longint'($urandom_range(0, 4000)) - 2000;
         f   = longint'($urandom_range(0, 4000)) - 2000;
         kp  = longint'($urandom_range(0, 4000));
         ki  = longint'($urandom_range(0, 40000));
         lim = longint'($urandom_range(100, 3000));
         strobe(r, f, kp, ki, -lim, lim, "R3/R4/R5 mixed pattern");
      end

      repeat (4) @(negedge clk);
      chk(scb.size(), 0, "R2 every strobe produced a result");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule